// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block holds a fixed configuration image and shifts it out one bit per rising clock edge to a downstream programmable device. Two inputs gate the readout. A combined reset/enable pin clears the read address when it sits at its reset level and allows counting otherwise. An active-low chip select lets the counter run and turns the serial driver on. The three-state serial output is modelled as a data bit plus a drive-enable bit.

When the last stored bit has been shifted out, the block stops driving its serial output and pulls its active-low cascade output low. Several readers can be chained by wiring each cascade output to the chip select of the next reader. Each reader then streams its share of the image in turn over one shared data line.

The read address has two parts: a row counter and a bit-within-row counter. The row count, the row width (24 or 32 bits) and the active level of the reset function are parameters. The image is built from a fixed arithmetic pattern.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `por_n` is low, the address returns to zero and `casc_n` is high. After `por_n` is released, with enable active and `cs_n` low, the first bit presented is the bit at address 0.
- R2: Whenever `oe_rst` is at its reset level, `data_oe` is 0 in the same cycle, whatever the value of `cs_n`.
- R3: A clock edge with `oe_rst` at its reset level clears the address and sets `casc_n` high. After that edge, readout restarts from address 0.
- R4: While `cs_n` is high, `data_oe` is 0 and clock edges do not move the address. When `cs_n` goes low again, the bit at the address reached before is presented.
- R5: When enable is active and `cs_n` is low, `data_oe` is 1 and `data_o` shows the bit at the current address. Each rising edge advances the address by one. The stored bit at address a is a[0] XOR a[2] XOR a[5].
- R6: The address is row*ROW_BITS + bit. The bit counter runs from 0 to ROW_BITS-1; on the next advance it returns to 0 and the row counter increments.
- R7: After ROWS*ROW_BITS advances, `casc_n` is low and `data_oe` is 0. Further edges leave both unchanged until a reset.
- R8: With RST_LEVEL=0, a low `oe_rst` is the reset level. With RST_LEVEL=1, a high `oe_rst` is the reset level and a low `oe_rst` enables readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edges advance the address |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| oe_rst | input | 1 | Combined counter reset / output enable; polarity set by RST_LEVEL |
| cs_n | input | 1 | Chip select, active low |
| data_o | output | 1 | Serial data bit at the current address |
| data_oe | output | 1 | Drive enable for data_o; 0 means high impedance |
| casc_n | output | 1 | Cascade output, low once all data has been sent |

## Verification
`data_oe` follows `oe_rst` and `cs_n` with no register in between, so it is checked in the same cycle as the input change. The address, `data_o` and `casc_n` move only on a rising edge, so their effect is checked in the cycle after that edge. The bench changes inputs on the falling edge and samples 3 ns later, still ahead of the next rising edge, so each sample sees exactly the edges counted so far. It sweeps every address of two configurations: a 24-bit-row image with low reset level, and a 32-bit-row image with high reset level. The expected bit at each step comes from the address arithmetic.

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int ROWS      = 16,
  parameter int ROW_BITS  = 24,
  parameter bit RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic oe_rst,
  input  logic cs_n,
  output logic data_o,
  output logic data_oe,
  output logic casc_n
);
  localparam int ROW_W = (ROWS > 2) ? $clog2(ROWS) : 1;
  localparam int BIT_W = $clog2(ROW_BITS);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(ROW_BITS - 1);

  logic [ROW_BITS-1:0] rom [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < ROW_BITS; b++) begin : g_bit
      localparam int A = r * ROW_BITS + b;
      assign rom[r][b] = 1'((A ^ (A >> 2) ^ (A >> 5)) & 1);
    end
  end

  logic [ROW_W-1:0] row_q;
  logic [BIT_W-1:0] bit_q;
  logic             done_q;
  logic             rst_act, adv, row_end, last;

  assign rst_act = (oe_rst == RST_LEVEL);
  assign adv     = !rst_act && !cs_n && !done_q;
  assign row_end = (bit_q == BIT_MAX);
  assign last    = row_end && (row_q == ROW_MAX);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      row_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (rst_act) begin
      row_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (adv) begin
      if (last) begin
        done_q <= 1'b1;
      end else if (row_end) begin
        bit_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign data_o  = rom[row_q][bit_q];
  assign data_oe = adv;
  assign casc_n  = !done_q;

  // R2
  float_on_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |-> !data_oe);

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |=> (row_q == '0 && bit_q == '0 && casc_n));

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_act && cs_n) |=> ($stable(row_q) && $stable(bit_q)));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!por_n)
    (adv && row_end && !last) |=> (bit_q == '0 && row_q == $past(row_q) + 1'b1));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !casc_n |-> !data_oe);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!casc_n && !rst_act) |=> !casc_n);
endmodule

// File: tb/sim_cfg_stream_reader.sv
module sim_cfg_stream_reader;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n;
  logic oe0, cs0, oe1, cs1;
  logic d0, e0, c0, d1, e1, c1;
  int checks = 0;
  int fails  = 0;
  int sel    = 0;

  cfg_stream_reader #(.ROWS(16), .ROW_BITS(24), .RST_LEVEL(1'b0)) u0 (
    .clk(clk), .por_n(por_n), .oe_rst(oe0), .cs_n(cs0),
    .data_o(d0), .data_oe(e0), .casc_n(c0));

  cfg_stream_reader #(.ROWS(4), .ROW_BITS(32), .RST_LEVEL(1'b1)) u1 (
    .clk(clk), .por_n(por_n), .oe_rst(oe1), .cs_n(cs1),
    .data_o(d1), .data_oe(e1), .casc_n(c1));

  function automatic logic pat(int a);
    return 1'((a ^ (a >> 2) ^ (a >> 5)) & 1);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic dout();  return sel ? d1 : d0; endfunction
  function automatic logic doe();   return sel ? e1 : e0; endfunction
  function automatic logic dcasc(); return sel ? c1 : c0; endfunction

  task automatic set_in(logic en, logic cs);
    if (sel == 0) begin oe0 = en ? 1'b1 : 1'b0; cs0 = cs; end
    else          begin oe1 = en ? 1'b0 : 1'b1; cs1 = cs; end
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic sweep(int total);
    // R8: the enable level follows the instance polarity
    set_in(1'b0, 1'b0);
    #3;
    chk("R2 oe off in reset", doe(), 1'b0);
    next();
    #3;
    chk("R3 casc high after reset", dcasc(), 1'b1);
    set_in(1'b1, 1'b1);
    #3;
    chk("R4 oe off with cs high", doe(), 1'b0);
    next();
    next();
    set_in(1'b1, 1'b0);
    #3;
    chk("R8 enable level drives", doe(), 1'b1);
    chk("R4 address frozen at 0", dout(), pat(0));
    for (int k = 0; k < total; k++) begin
      chk("R5 data", dout(), pat(k));
      chk("R5 oe on", doe(), 1'b1);
      chk("R6 casc high midstream", dcasc(), 1'b1);
      if (k == 10) begin
        next();
        set_in(1'b1, 1'b1);
        #3;
        chk("R4 oe off paused", doe(), 1'b0);
        next();
        next();
        set_in(1'b1, 1'b0);
        #3;
        chk("R4 resumes at address", dout(), pat(11));
        continue;
      end
      next();
      #3;
    end
    chk("R7 casc low at end", dcasc(), 1'b0);
    chk("R7 oe off at end", doe(), 1'b0);
    next(); next(); next();
    #3;
    chk("R7 casc holds", dcasc(), 1'b0);
    chk("R7 oe stays off", doe(), 1'b0);
    set_in(1'b0, 1'b0);
    #3;
    chk("R2 oe off in reset", doe(), 1'b0);
    next();
    set_in(1'b1, 1'b0);
    #3;
    chk("R3 casc high", dcasc(), 1'b1);
    chk("R3 restart at 0", dout(), pat(0));
    for (int k = 0; k < 40; k++) begin
      chk("R6 row sequence", dout(), pat(k));
      next();
      #3;
    end
    set_in(1'b0, 1'b0);
    next();
    set_in(1'b1, 1'b1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog R5: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0;
    oe0 = 1'b1; cs0 = 1'b0;
    oe1 = 1'b0; cs1 = 1'b0;
    next(); next();
    #3;
    chk("R1 casc high in por u0", c0, 1'b1);
    chk("R1 casc high in por u1", c1, 1'b1);
    chk("R1 first bit u0", d0, pat(0));
    por_n = 1'b1;
    #1;
    chk("R1 oe on after por", e0, 1'b1);
    cs0 = 1'b1; cs1 = 1'b1;
    next();
    sel = 0;
    sweep(16 * 24);
    sel = 1;
    sweep(4 * 32);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule